// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the output end of a sigma-delta converter's decimation stage, seen from the host that reads it. A word-rate generator divides the converter clock by a ratio chosen with a 3-bit rate code. Each time it expires, a new 24-bit conversion word is produced from a deterministic test sequence, and the data-ready flag is raised. The filtering arithmetic is not part of the block.

The host reads by pulling chip select low with the read/write line high. A select line picks the 24-bit data word or an 8-bit status word. The first bit of the chosen word drives the serial output at once, with no clock edge needed. The shift clock is oversampled and edge-detected in the converter clock domain, so it must stay at most a quarter of that clock. A conversion that completes while a read is selected is parked in a holding register and loaded when the read ends, so the word being shifted never changes.

Top module: `conv_readout_port`

## Requirements
- R1: After reset `drdy` is 0, `sod` is 0 and the data buffer reads as zero.
- R2: `sod` is 0 whenever `cs_n` is high or `rw` is low.
- R3: When `cs_n` goes low with `rw` high, the first (most significant) bit of the selected word appears on `sod` before any clock edge. It stays there through any `sclk` rising edge that comes before the first `sclk` falling edge, and through that falling edge.
- R4: After the first falling edge, each `sclk` rising edge presents the next lower bit. The data word is 24 bits sent MSB first. Once the falling edge after the last bit has passed, `sod` is 0 until the read ends.
- R5: `rsel`=0 selects the data word; `rsel`=1 selects the 8-bit status word, whose bit 7 is `drdy`, bit 6 is the pending flag (a word held back by a read), bits 5..3 are 0 and bits 2..0 are the rate code. The status word is captured on the last cycle before the read is selected.
- R6: For rate code c from 1 to 7, a new word is produced every 250·2^(c-1) cycles of `clk_in` (4 kHz down to 62.5 Hz at 1 MHz). Code 0 produces no words. Any change of code restarts the interval.
- R7: The n-th word produced since reset has the value (n · 0x9E3779) mod 2^24. A repeated read returns the same word.
- R8: `drdy` rises in the cycle after a word is loaded into the data buffer. It falls when a data read passes the falling edge after its 24th bit.
- R9: `drdy` falls when `cs_n` is released after the first falling edge of a data read. A status read leaves `drdy` unchanged.
- R10: A word produced while a read is selected does not alter the word being shifted. It is loaded, and `drdy` raised, once the read is deselected.
- R11: With `cs_n` low and `rw` low, `sclk` edges neither advance the bit position nor clear `drdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Converter clock (1 MHz nominal); all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | High for a read |
| rsel | input | 1 | 0 selects the data word, 1 the status word |
| sclk | input | 1 | Serial shift clock from the host |
| rate | input | 3 | Word-rate code, 0 = stopped |
| sod | output | 1 | Serial data output, low when not reading |
| drdy | output | 1 | Data-ready flag |

## Verification
Reads are made with the shift clock idling both high and low at selection, and with randomly stretched bit periods. Starting low tells apart a design that wrongly advances on the early rising edge; the stretched periods expose one that counts cycles instead of edges. Every rate code is timed from one data-ready edge to the next, which separates the divide ratios and shows whether the interval restarts on a code change. Separate sequences cover a read that is aborted, a status-only read, a selection with `rw` low, and a read held open across a conversion. Together these tell the two ways of clearing the flag apart from the ways that must not clear it, and a held word from an overwritten one.

// File: rtl/conv_readout_port.sv
module conv_readout_port #(
  parameter int WORD_W = 24,
  parameter int STAT_W = 8,
  parameter int RATE_W = 3,
  parameter int BASE_DIV = 250,
  parameter int unsigned SAMPLE_MUL = 32'h009E_3779
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              rsel,
  input  logic              sclk,
  input  logic [RATE_W-1:0] rate,
  output logic              sod,
  output logic              drdy
);
  localparam int MAX_DIV = BASE_DIV << ((1 << RATE_W) - 2);
  localparam int CNT_W = $clog2(MAX_DIV + 1);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] D_LAST = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] S_LAST = IDX_W'(STAT_W - 1);

  logic sel;
  assign sel = !cs_n && rw;

  logic [2:0] sk;
  logic rise, fall;
  assign rise = sk[1] & ~sk[2];
  assign fall = ~sk[1] & sk[2];

  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0] cnt, lim;
  logic tick;
  assign lim  = CNT_W'(BASE_DIV) << (rate - RATE_W'(1));
  assign tick = (rate != '0) && (rate == rate_q) && (cnt == lim - 1'b1);

  logic [WORD_W-1:0] nconv, new_word, data_buf, pend_word;
  logic pend;
  assign new_word = (nconv + 1'b1) * WORD_W'(SAMPLE_MUL);

  logic load_new, load_pend;
  assign load_new  = tick && !sel;
  assign load_pend = !sel && pend && !tick;

  logic [STAT_W-1:0] stat_buf;
  logic [IDX_W-1:0] idx, last;
  logic armed, done, rsel_q;
  assign last = rsel ? S_LAST : D_LAST;

  logic data_done, abort;
  assign data_done = sel && fall && armed && !done && !rsel && idx == D_LAST;
  assign abort     = !sel && armed && !done && !rsel_q;

  logic [WORD_W-1:0] dsh;
  logic [STAT_W-1:0] ssh;
  assign dsh = data_buf << idx;
  assign ssh = stat_buf << idx;
  assign sod = sel && !done && (rsel ? ssh[STAT_W-1] : dsh[WORD_W-1]);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      sk     <= '0;
      rate_q <= '0;
      cnt    <= '0;
    end else begin
      sk     <= {sk[1:0], sclk};
      rate_q <= rate;
      if (rate == '0 || rate != rate_q || tick) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      nconv     <= '0;
      data_buf  <= '0;
      pend_word <= '0;
      pend      <= 1'b0;
      drdy      <= 1'b0;
    end else begin
      if (tick) nconv <= nconv + 1'b1;
      if (tick && sel) begin
        pend      <= 1'b1;
        pend_word <= new_word;
      end else if (load_new) begin
        pend     <= 1'b0;
        data_buf <= new_word;
      end else if (load_pend) begin
        pend     <= 1'b0;
        data_buf <= pend_word;
      end
      if (load_new || load_pend) drdy <= 1'b1;
      else if (data_done || abort) drdy <= 1'b0;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      stat_buf <= '0;
      idx      <= '0;
      armed    <= 1'b0;
      done     <= 1'b0;
      rsel_q   <= 1'b0;
    end else if (!sel) begin
      stat_buf <= {drdy, pend, {(STAT_W-2-RATE_W){1'b0}}, rate};
      idx      <= '0;
      armed    <= 1'b0;
      done     <= 1'b0;
    end else begin
      rsel_q <= rsel;
      if (fall) armed <= 1'b1;
      if (fall && armed && idx == last) done <= 1'b1;
      if (rise && armed && !done && idx != last) idx <= idx + 1'b1;
    end
  end
endmodule

module conv_readout_port_chk #(
  parameter int WORD_W = 24
) (
  input logic                       clk_in,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic                       rw,
  input logic                       sod,
  input logic                       drdy,
  input logic                       armed,
  input logic [$clog2(WORD_W)-1:0]  idx,
  input logic [WORD_W-1:0]          data_buf
);
  logic sel;
  assign sel = !cs_n && rw;

  p_sod_idle_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cs_n || !rw) |-> !sod);

  p_no_adv_before_arm_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
    !armed |-> idx == '0);

  p_idx_range_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    idx <= ($clog2(WORD_W))'(WORD_W - 1));

  p_drdy_fall_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
    $fell(drdy) |-> $past(armed));

  p_hold_buf_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
    (sel && $past(sel)) |-> $stable(data_buf));

  p_load_idle_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(drdy) |-> $past(!sel));
endmodule

bind conv_readout_port conv_readout_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .sod(sod),
  .drdy(drdy), .armed(armed), .idx(idx), .data_buf(data_buf)
);

// File: tb/sim_conv_readout_port.sv
`timescale 1ns/1ps
module sim_conv_readout_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b0, rsel = 1'b0, sclk = 1'b0;
  logic [2:0] rate = 3'd0;
  logic sod, drdy;

  int checks = 0, errors = 0;
  int cyc = 0, rises = 0, last_rise = 0, prev_rise = 0;
  logic drdy_prev = 1'b0;

  conv_readout_port u0 (
    .clk_in(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .rsel(rsel),
    .sclk(sclk), .rate(rate), .sod(sod), .drdy(drdy)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (drdy && !drdy_prev) begin
      rises++;
      prev_rise = last_rise;
      last_rise = cyc;
    end
    drdy_prev = drdy;
  end

  function automatic logic [23:0] exp_word(input int n);
    logic [63:0] p;
    p = 64'(n) * 64'h9E3779;
    return p[23:0];
  endfunction

  function automatic int exp_period(input int c);
    return 250 << (c - 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(input int limit);
    int r0, k;
    r0 = rises; k = 0;
    while (rises == r0 && k < limit) begin idle(1); k++; end
    chk("R8 drdy rise seen", 32'(rises != r0), 32'd1);
  endtask

  task automatic read_word(input logic rs, input int nbits, output logic [23:0] val);
    logic b0;
    val = '0;
    sclk = 1'($urandom_range(0, 1));
    idle(3);
    rsel = rs; rw = 1'b1; cs_n = 1'b0;
    #1 b0 = sod;
    val = {val[22:0], b0};
    if (!sclk) begin
      idle(2); sclk = 1'b1; idle(3);
      chk("R3 first bit kept over early rise", 32'(sod), 32'(b0));
    end
    idle(1); sclk = 1'b0; idle(3);
    chk("R3 first bit kept over first fall", 32'(sod), 32'(b0));
    for (int i = 1; i < nbits; i++) begin
      sclk = 1'b1; idle(3 + $urandom_range(0, 1));
      val = {val[22:0], sod};
      sclk = 1'b0; idle(3);
    end
    chk("R4 sod low after last bit", 32'(sod), 32'd0);
    cs_n = 1'b1;
    idle(1);
  endtask

  logic [23:0] v;
  int n0;

  initial begin
    idle(3);
    chk("R1 drdy after reset", 32'(drdy), 32'd0);
    chk("R1 sod after reset", 32'(sod), 32'd0);
    rst_n = 1'b1;
    idle(2);
    cs_n = 1'b0; rw = 1'b0; idle(1);
    chk("R2 sod low with rw low", 32'(sod), 32'd0);
    cs_n = 1'b1; rw = 1'b1; idle(1);
    chk("R2 sod low with cs_n high", 32'(sod), 32'd0);
    read_word(1'b0, 24, v);
    chk("R1 data buffer zero after reset", 32'(v), 32'd0);
    idle(3000);
    chk("R6 code 0 produces no word", 32'(rises), 32'd0);

    for (int c = 1; c <= 7; c++) begin
      rate = 3'(c);
      wait_rise(exp_period(c) + 20);
      read_word(1'b0, 24, v);
      chk("R7 data word value", 32'(v), 32'(exp_word(rises)));
      chk("R8 drdy cleared by data read", 32'(drdy), 32'd0);
      wait_rise(exp_period(c) + 20);
      chk("R6 word interval", 32'(last_rise - prev_rise), 32'(exp_period(c)));
      read_word(1'b0, 24, v);
      chk("R4 R7 data word MSB first", 32'(v), 32'(exp_word(rises)));
    end

    rate = 3'd1;
    for (int k = 0; k < 6; k++) begin
      wait_rise(300);
      read_word(1'b0, 24, v);
      chk("R7 random paced read", 32'(v), 32'(exp_word(rises)));
    end

    rate = 3'd2;
    wait_rise(600);
    n0 = rises;
    sclk = 1'b1; idle(3);
    rsel = 1'b0; rw = 1'b1; cs_n = 1'b0;
    #1 v = {23'd0, sod};
    idle(1); sclk = 1'b0; idle(3);
    idle(600);
    chk("R10 drdy untouched by held word", 32'(drdy), 32'd1);
    for (int i = 1; i < 24; i++) begin
      sclk = 1'b1; idle(3);
      v = {v[22:0], sod};
      sclk = 1'b0; idle(3);
    end
    chk("R10 shifted word not corrupted", 32'(v), 32'(exp_word(n0)));
    idle(20);
    chk("R10 held word not loaded while selected", 32'(drdy), 32'd0);
    cs_n = 1'b1; idle(2);
    chk("R10 held word loaded on deselect", 32'(drdy), 32'd1);
    chk("R10 one new word counted", 32'(rises), 32'(n0 + 1));
    read_word(1'b0, 24, v);
    chk("R10 held word value", 32'(v), 32'(exp_word(n0 + 1)));

    rate = 3'd0; idle(3);
    while (drdy) begin
      read_word(1'b0, 24, v);
      chk("R7 drain read", 32'(v), 32'(exp_word(rises)));
      idle(3);
    end
    rate = 3'd1;
    wait_rise(300);
    rate = 3'd0;
    idle(3);

    read_word(1'b1, 8, v);
    chk("R5 status word with drdy set", 32'(v[7:0]), 32'h80);
    chk("R9 status read keeps drdy", 32'(drdy), 32'd1);

    rsel = 1'b0; rw = 1'b0; cs_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sclk = ~sclk; idle(4);
      chk("R11 sod low with rw low", 32'(sod), 32'd0);
    end
    chk("R11 drdy kept with rw low", 32'(drdy), 32'd1);
    rw = 1'b1; idle(1);
    chk("R11 no shift with rw low", 32'(sod), 32'(exp_word(rises) >> 23));
    cs_n = 1'b1; idle(2);

    sclk = 1'b1; idle(3);
    rsel = 1'b0; rw = 1'b1; cs_n = 1'b0; idle(1);
    sclk = 1'b0; idle(3);
    sclk = 1'b1; idle(3);
    chk("R4 second bit after first rise", 32'(sod), 32'(exp_word(rises) >> 22) & 32'd1);
    chk("R9 drdy held mid read", 32'(drdy), 32'd1);
    cs_n = 1'b1; idle(2);
    chk("R9 drdy cleared by abort", 32'(drdy), 32'd0);

    read_word(1'b1, 8, v);
    chk("R5 status word after abort", 32'(v[7:0]), 32'h00);
    read_word(1'b0, 24, v);
    chk("R7 repeat read same word", 32'(v), 32'(exp_word(rises)));

    rate = 3'd5; idle(5);
    read_word(1'b1, 8, v);
    chk("R5 status reports rate code", 32'(v[7:0]), 32'h05);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule